// File: doc/BRIEF.md
# Converter Start-Up Calibration Sequencer

This block is the digital start-up controller of a sampling converter. It runs on the converter's sampling reference clock. It watches an active-low initialisation request line and drives an active-low busy flag. The busy flag is held low while a calibration phase runs. When calibration finishes, the block raises a ready flag. The analog calibration itself is not modelled. A cycle counter of programmable length stands in for it.

The block has no power-on self-start. After power-up its registers take a defined idle value. The block stays uncalibrated until the request line has been held low long enough and then released. The block ignores request pulses that are too short, so glitches cannot disturb a running calibration or a calibrated converter. A valid request at any time aborts whatever is in progress, and its release starts the full sequence again from the beginning.

Top module: `cal_sequencer`

## Requirements
- R1: After power-up, with no valid request applied, `busy_n_o` stays 1 and `ready_o` stays 0 however long the clock runs.
- R2: A request counts as valid only when `init_n_i` is sampled 0 on at least MIN_LOW_CYCLES (default 3) consecutive rising clock edges. A shorter low pulse leaves the outputs unchanged: an uninitialised block does not start, a running calibration keeps its original end time, and `ready_o` stays 1.
- R3: At the clock edge that takes the MIN_LOW_CYCLES-th consecutive low sample, `busy_n_o` becomes 1 and `ready_o` becomes 0. Both hold these values for as long as the line stays low.
- R4: After a valid request, the first rising edge that samples `init_n_i` high drives `busy_n_o` to 0. This is one clock cycle after release, which is inside the two-cycle bound.
- R5: Once asserted, `busy_n_o` stays 0 for exactly CAL_CYCLES+1 clock cycles: one start cycle followed by CAL_CYCLES counting cycles. It then returns to 1.
- R6: `ready_o` rises exactly one cycle after `busy_n_o` returns to 1 at the end of a calibration. It stays 1 until the next valid request.
- R7: A valid request while `busy_n_o` is 0 aborts the calibration. The following release starts a new calibration of the full CAL_CYCLES+1 length.
- R8: `busy_n_o` is always driven to 0 or 1, including before the first request.
- R9: `ready_o` is never 1 while `busy_n_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling reference clock; all logic on its rising edge |
| init_n_i | input | 1 | Active-low initialisation request, sampled synchronously |
| busy_n_o | output | 1 | Active-low calibration-in-progress flag, registered |
| ready_o | output | 1 | High once a calibration has completed, registered |

## Verification
Several properties are checked on every cycle. Busy is always at a known level, and ready is never high while busy is low. Any fall of busy follows a low-to-high release of the request line. A long enough low run forces busy high and ready low. Ready rises only after busy has already been high for a cycle. Each calibration that is not cut short lasts exactly CAL_CYCLES+1 cycles. The directed scenarios show what the per-cycle properties cannot: no self-start after power-up, short pulses that neither start nor stretch a calibration, the abort-and-restart path, and the exact boundary between a two-cycle and a three-cycle low.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE_UNCAL = 3'd0,
        PH_HOLD       = 3'd1,
        PH_ARM        = 3'd2,
        PH_CAL        = 3'd3,
        PH_DONE       = 3'd4
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   busy_n;
        logic   ready;
    } seq_regs_t;

    localparam seq_regs_t SEQ_POWERUP = '{phase: PH_IDLE_UNCAL, busy_n: 1'b1, ready: 1'b0};

endpackage

// File: rtl/init_pulse_qualifier.sv
module init_pulse_qualifier #(
    parameter int MIN_LOW = 3
) (
    input  logic clk_i,
    input  logic line_n_i,
    output logic valid_o
);
    localparam int W = $clog2(MIN_LOW + 1);
    localparam logic [W-1:0] SAT  = W'(MIN_LOW);
    localparam logic [W-1:0] LAST = W'(MIN_LOW - 1);

    logic [W-1:0] run_q = '0;
    logic [W-1:0] run_d;

    // count consecutive low samples, saturating; any high sample clears
    always_comb begin
        if (line_n_i) begin
            run_d = '0;
        end else if (run_q == SAT) begin
            run_d = run_q;
        end else begin
            run_d = run_q + 1'b1;
        end
        valid_o = !line_n_i && (run_q >= LAST);
    end

    always_ff @(posedge clk_i) begin
        run_q <= run_d;
    end

endmodule

// File: rtl/cal_timer.sv
module cal_timer #(
    parameter int CYCLES = 750000
) (
    input  logic clk_i,
    input  logic clear_i,
    input  logic run_i,
    output logic last_o
);
    localparam int W = $clog2(CYCLES + 1);
    localparam logic [W-1:0] END_CNT = W'(CYCLES - 1);

    logic [W-1:0] cnt_q = '0;
    logic [W-1:0] cnt_d;

    always_comb begin
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
        last_o = run_i && (cnt_q == END_CNT);
    end

    always_ff @(posedge clk_i) begin
        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
    import cal_seq_pkg::*;
#(
    parameter int CAL_CYCLES     = 750000,
    parameter int MIN_LOW_CYCLES = 3
) (
    input  logic clk_i,
    input  logic init_n_i,
    output logic busy_n_o,
    output logic ready_o
);
    seq_regs_t r_q = SEQ_POWERUP;
    seq_regs_t r_d;

    logic low_valid;
    logic cal_last;
    logic cal_run;
    logic cal_clear;

    init_pulse_qualifier #(.MIN_LOW(MIN_LOW_CYCLES)) u_qual (
        .clk_i    (clk_i),
        .line_n_i (init_n_i),
        .valid_o  (low_valid)
    );

    assign cal_run   = (r_q.phase == PH_CAL);
    assign cal_clear = (r_q.phase != PH_CAL);

    cal_timer #(.CYCLES(CAL_CYCLES)) u_timer (
        .clk_i   (clk_i),
        .clear_i (cal_clear),
        .run_i   (cal_run),
        .last_o  (cal_last)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.phase)
            PH_HOLD:  if (init_n_i) r_d.phase = PH_ARM;
            PH_ARM:   r_d.phase = PH_CAL;
            PH_CAL:   if (cal_last) r_d.phase = PH_DONE;
            default:  r_d.phase = r_q.phase;
        endcase
        // a qualified request overrides every phase
        if (low_valid) begin
            r_d.phase = PH_HOLD;
        end
        r_d.busy_n = !((r_d.phase == PH_ARM) || (r_d.phase == PH_CAL));
        r_d.ready  = (r_q.phase == PH_DONE) && (r_d.phase == PH_DONE);
    end

    always_ff @(posedge clk_i) begin
        r_q <= r_d;
    end

    assign busy_n_o = r_q.busy_n;
    assign ready_o  = r_q.ready;

endmodule

// File: rtl/cal_sequencer_chk.sv
module cal_sequencer_chk #(
    parameter int CAL_CYCLES = 750000,
    parameter int MIN_LOW    = 3
) (
    input logic clk_i,
    input logic init_n_i,
    input logic busy_n_o,
    input logic ready_o
);
    logic [1:0] age_q = 2'd0;
    int         busy_len_q = 0;
    int         low_run_q  = 0;
    logic       live;

    assign live = (age_q == 2'd3);

    always_ff @(posedge clk_i) begin
        if (age_q != 2'd3) age_q <= age_q + 2'd1;
        busy_len_q <= busy_n_o ? 0 : busy_len_q + 1;
        if (init_n_i)              low_run_q <= 0;
        else if (low_run_q < MIN_LOW) low_run_q <= low_run_q + 1;
    end

    // R8: busy output always at a defined level
    a_r8_busy_defined: assert property (@(posedge clk_i)
        (busy_n_o == 1'b0) || (busy_n_o == 1'b1));

    // R9: ready never overlaps busy
    a_r9_ready_not_busy: assert property (@(posedge clk_i) disable iff (!live)
        ready_o |-> busy_n_o);

    // R4: busy only falls right after a low-to-high release
    a_r4_busy_after_release: assert property (@(posedge clk_i) disable iff (!live)
        $fell(busy_n_o) |-> ($past(init_n_i) && !$past(init_n_i, 2)));

    // R3: a qualified low forces idle outputs on the next cycle
    a_r3_hold_forces_idle: assert property (@(posedge clk_i) disable iff (!live)
        (!init_n_i && (low_run_q >= MIN_LOW - 1)) |=> (busy_n_o && !ready_o));

    // R6: ready rises only after busy has been high a cycle
    a_r6_ready_follows: assert property (@(posedge clk_i) disable iff (!live)
        $rose(ready_o) |-> ($past(busy_n_o) && busy_n_o));

    // R5: an uninterrupted calibration lasts CAL_CYCLES+1 cycles
    a_r5_cal_length: assert property (@(posedge clk_i) disable iff (!live)
        ($rose(busy_n_o) && $past(init_n_i)) |-> (busy_len_q == CAL_CYCLES + 1));

endmodule

bind cal_sequencer cal_sequencer_chk #(
    .CAL_CYCLES (CAL_CYCLES),
    .MIN_LOW    (MIN_LOW_CYCLES)
) u_chk (
    .clk_i    (clk_i),
    .init_n_i (init_n_i),
    .busy_n_o (busy_n_o),
    .ready_o  (ready_o)
);

// File: tb/tb_cal_sequencer.sv
module tb_cal_sequencer;
    localparam int CAL = 20;
    localparam int EXP_LEN = CAL + 1;

    logic clk = 1'b0;
    logic init_n = 1'b1;
    logic busy_n;
    logic ready;
    int   vectors = 0;
    int   miscompares = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    cal_sequencer #(.CAL_CYCLES(CAL), .MIN_LOW_CYCLES(3)) dut (
        .clk_i    (clk),
        .init_n_i (init_n),
        .busy_n_o (busy_n),
        .ready_o  (ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hold_low(input int n);
        init_n = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic start_cal();
        hold_low(3);
        chk(busy_n === 1'b1, "R3 busy high in hold", busy_n, 1);
        chk(ready === 1'b0, "R3 ready low in hold", ready, 0);
        init_n = 1'b1;
        @(negedge clk);
        chk(busy_n === 1'b0, "R4 busy low one cycle after release", busy_n, 0);
    endtask

    task automatic measure(output int len);
        len = 0;
        while (busy_n === 1'b0 && len < 2000) begin
            if (ready !== 1'b0) chk(1'b0, "R9 ready during busy", ready, 0);
            len++;
            @(negedge clk);
        end
    endtask

    task automatic t_powerup();
        int bad = 0;
        @(negedge clk);
        chk(busy_n === 1'b0 || busy_n === 1'b1, "R8 busy defined at power-up", busy_n, 1);
        for (int i = 0; i < 50; i++) begin
            if (busy_n !== 1'b1 || ready !== 1'b0) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R1 no self start", bad, 0);
        hold_low(2);
        init_n = 1'b1;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (busy_n !== 1'b1 || ready !== 1'b0) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R2 short pulse from uninit ignored", bad, 0);
    endtask

    task automatic t_nominal();
        int len;
        start_cal();
        measure(len);
        chk(len == EXP_LEN, "R5 busy low length", len, EXP_LEN);
        chk(ready === 1'b0, "R6 ready not yet", ready, 0);
        @(negedge clk);
        chk(ready === 1'b1, "R6 ready one cycle after busy", ready, 1);
        repeat (10) @(negedge clk);
        chk(ready === 1'b1 && busy_n === 1'b1, "R6 ready holds", ready, 1);
    endtask

    task automatic t_short_in_ready();
        hold_low(2);
        chk(ready === 1'b1, "R2 ready kept during short pulse", ready, 1);
        init_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(ready === 1'b1 && busy_n === 1'b1, "R2 ready kept after short pulse", ready, 1);
    endtask

    task automatic t_short_mid_cal();
        int len;
        start_cal();
        repeat (4) @(negedge clk);
        hold_low(2);
        chk(busy_n === 1'b0, "R2 calibration continues over short pulse", busy_n, 0);
        init_n = 1'b1;
        measure(len);
        chk(len + 6 == EXP_LEN, "R2 end time unchanged by short pulse", len + 6, EXP_LEN);
        @(negedge clk);
        chk(ready === 1'b1, "R6 ready after stretched-free calibration", ready, 1);
    endtask

    task automatic t_abort();
        int len;
        start_cal();
        repeat (8) @(negedge clk);
        hold_low(2);
        chk(busy_n === 1'b0, "R2 two lows do not abort", busy_n, 0);
        @(negedge clk);
        chk(busy_n === 1'b1 && ready === 1'b0, "R7 third low aborts", busy_n, 1);
        init_n = 1'b1;
        @(negedge clk);
        chk(busy_n === 1'b0, "R7 restart after abort", busy_n, 0);
        measure(len);
        chk(len == EXP_LEN, "R7 full length after restart", len, EXP_LEN);
        @(negedge clk);
        chk(ready === 1'b1, "R6 ready after restarted calibration", ready, 1);
    endtask

    task automatic t_long_low();
        int bad = 0;
        int len;
        hold_low(3);
        for (int i = 0; i < 12; i++) begin
            if (busy_n !== 1'b1 || ready !== 1'b0) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R3 outputs idle through long low", bad, 0);
        init_n = 1'b1;
        @(negedge clk);
        chk(busy_n === 1'b0, "R4 busy after long low release", busy_n, 0);
        measure(len);
        chk(len == EXP_LEN, "R5 length after long low", len, EXP_LEN);
    endtask

    initial begin
        t_powerup();
        t_nominal();
        t_short_in_ready();
        t_short_mid_cal();
        t_abort();
        t_long_low();
        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule